// File: doc/BRIEF.md
# Multi-Comparator Event Timer

This block is a memory-mapped event timer. One 32-bit main counter runs freely while a global enable bit is set. A parameterised set of comparators, three by default, watches that counter. Each comparator either raises its event once, when the counter reaches the programmed value, or keeps raising it at a fixed period. In the periodic case the comparator advances by the stored period after each match.

Software reaches the block through a simple 32-bit register port. The port carries one write strobe and a combinational read-data path, and a read has no side effects. The block raises events three ways: a shared status register that is cleared by writing ones, one interrupt line per timer (level or single-cycle pulse), and two legacy lines. When legacy routing is on, the legacy lines take over timers 0 and 1.

Top module: `evt_timer`

## Requirements
- R1: After reset, the capability word at 0x000 reads vendor ID in bits 31:16, legacy-route-capable flag set in bit 15, 64-bit-counter flag clear in bit 13, timer count minus one in bits 12:8 and revision in bits 7:0. The tick length at 0x004 reads the nonzero femtosecond parameter. The global word (0x010), status (0x020), counter (0x0F0) and all interrupt lines read 0, and each timer configuration word (0x100+0x20·n) reads 0x10, which is only the periodic-capable flag in bit 4.
- R2: While global enable (bit 0 of 0x010) is set, the main counter at 0x0F0 rises by exactly one per clock. While enable is clear, the counter holds its value.
- R3: A write to 0x0F0 loads the counter only while enable is clear. While enable is set, such a write is ignored.
- R4: A one-shot timer (configuration bit 3 clear) sets its status bit one clock after the counter equals its comparator (0x108+0x20·n). It does so only once per comparator write; passing the same value again does not set status again.
- R5: A periodic timer (bit 3 set) adds its stored period to its comparator on every match, modulo 2^32. It therefore matches again one period later.
- R6: Writing a configuration word with value-set (bit 6) high arms a two-write handshake. The next comparator write loads the match value and the one after loads the period. Bit 6 reads 1 until the period write and 0 after it.
- R7: Writing the status register clears every bit written as 1 and leaves the bits written as 0 unchanged. A match in the same clock wins over the clear.
- R8: With level type (bit 1 = 1) and interrupt enable (bit 2 = 1), a timer's line stays high for as long as its status bit is set.
- R9: With edge type (bit 1 = 0) and interrupt enable set, a timer's line pulses high for exactly one clock per match.
- R10: When legacy route (bit 1 of 0x010) is set, timer 0 drives legacy_irq0 and timer 1 drives legacy_irq8, and lines tmr_irq[0] and tmr_irq[1] stay low. With legacy route clear, both legacy lines stay low.
- R11: With interrupt enable clear, a match still sets the status bit, but the timer's line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tmr_irq | output | NUM_TMR | Per-timer interrupt lines |
| legacy_irq0 | output | 1 | Legacy line taking timer 0 under legacy route |
| legacy_irq8 | output | 1 | Legacy line taking timer 1 under legacy route |

## Verification
The bound checker checks on every clock that the counter steps by one when enabled and holds otherwise, and that a match always leaves its status bit set. It also checks that legacy route masks the first two per-timer lines and that, with legacy route clear, both legacy lines stay idle. Only the directed scenarios can show that a one-shot does not refire, that the value-set sequence lands the period in the right place, that periodic pulses come at the right spacing with the final comparator value, and that status clearing is selective.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

    localparam int CW = 32;

    // Global register offsets (byte addresses)
    localparam int OFF_CAPS   = 'h000;
    localparam int OFF_TICK   = 'h004;
    localparam int OFF_GCFG   = 'h010;
    localparam int OFF_STAT   = 'h020;
    localparam int OFF_CNT    = 'h0F0;
    localparam int TMR_BASE   = 'h100;
    localparam int TMR_STRIDE = 'h020;
    localparam int TMR_CMP    = 'h008;

    // Per-timer configuration bit positions
    localparam int TB_LVL   = 1;
    localparam int TB_IE    = 2;
    localparam int TB_PER   = 3;
    localparam int TB_PCAP  = 4;
    localparam int TB_W64   = 5;
    localparam int TB_VSET  = 6;
    localparam int TB_F32   = 8;
    localparam int TB_ROUTE = 9;
    localparam int ROUTE_W  = 5;

    typedef enum logic [1:0] {
        VS_IDLE  = 2'd0,
        VS_VALUE = 2'd1,
        VS_PERIOD = 2'd2
    } vs_stage_e;

    typedef struct packed {
        logic [CW-1:0]      cmp;
        logic [CW-1:0]      period;
        logic               ie;
        logic               lvl;
        logic               per;
        logic               f32;
        logic [ROUTE_W-1:0] route;
        vs_stage_e          vs;
        logic               armed;
    } cmp_st_t;

    function automatic int tmr_cfg_addr(input int n);
        return TMR_BASE + n * TMR_STRIDE;
    endfunction

    function automatic int tmr_cmp_addr(input int n);
        return TMR_BASE + n * TMR_STRIDE + TMR_CMP;
    endfunction

endpackage

// File: rtl/evt_main_ctr.sv
module evt_main_ctr
    import evt_tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cnt_q
);

    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (ld) begin
            cnt_d = ld_val;
        end else if (run) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/evt_cmp_unit.sv
module evt_cmp_unit
    import evt_tmr_pkg::*;
#(
    parameter bit PER_CAP = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          cnt_en,
    input  logic          cfg_we,
    input  logic          cmp_we,
    input  logic [31:0]   wdata,
    output logic [31:0]   cfg_rd,
    output logic [31:0]   cmp_rd,
    output logic          match,
    output logic          ie,
    output logic          lvl
);

    cmp_st_t st_d, st_q;
    logic    unused_wbits;

    assign unused_wbits = ^{wdata[31:14], wdata[7], wdata[5], wdata[4], wdata[0]};

    assign match = cnt_en && st_q.armed && (cnt == st_q.cmp);

    always_comb begin
        st_d = st_q;
        if (match) begin
            if (st_q.per) begin
                st_d.cmp = st_q.cmp + st_q.period;
            end else begin
                st_d.armed = 1'b0;
            end
        end
        if (cfg_we) begin
            st_d.lvl   = wdata[TB_LVL];
            st_d.ie    = wdata[TB_IE];
            st_d.per   = wdata[TB_PER] & PER_CAP;
            st_d.f32   = wdata[TB_F32];
            st_d.route = wdata[TB_ROUTE +: ROUTE_W];
            if (wdata[TB_VSET]) begin
                st_d.vs = VS_VALUE;
            end
        end
        if (cmp_we) begin
            unique case (st_q.vs)
                VS_PERIOD: begin
                    st_d.period = wdata;
                    st_d.vs     = VS_IDLE;
                end
                VS_VALUE: begin
                    st_d.cmp   = wdata;
                    st_d.armed = 1'b1;
                    st_d.vs    = VS_PERIOD;
                end
                default: begin
                    st_d.cmp   = wdata;
                    st_d.armed = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.cmp    <= '1;
            st_q.vs     <= VS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rd                         = '0;
        cfg_rd[TB_LVL]                 = st_q.lvl;
        cfg_rd[TB_IE]                  = st_q.ie;
        cfg_rd[TB_PER]                 = st_q.per;
        cfg_rd[TB_PCAP]                = PER_CAP;
        cfg_rd[TB_W64]                 = 1'b0;
        cfg_rd[TB_VSET]                = (st_q.vs != VS_IDLE);
        cfg_rd[TB_F32]                 = st_q.f32;
        cfg_rd[TB_ROUTE +: ROUTE_W]    = st_q.route;
    end

    assign cmp_rd = st_q.cmp;
    assign ie     = st_q.ie;
    assign lvl    = st_q.lvl;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_tmr_pkg::*;
#(
    parameter int          NUM_TMR   = 3,
    parameter int          ADDR_W    = 12,
    parameter logic [15:0] VENDOR_ID = 16'h5A17,
    parameter logic [7:0]  REV_ID    = 8'h01,
    parameter logic [31:0] TICK_FS   = 32'd10_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_TMR-1:0] tmr_irq,
    output logic              legacy_irq0,
    output logic              legacy_irq8
);

    localparam logic [31:0] CAPS_WORD = {VENDOR_ID, 1'b1, 1'b0, 1'b0,
                                         5'(NUM_TMR - 1), REV_ID};

    typedef struct packed {
        logic               en;
        logic               leg;
        logic [NUM_TMR-1:0] stat;
        logic [NUM_TMR-1:0] pulse;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CW-1:0]      cnt_q;
    logic               ctr_en, ctr_ld, leg_w;
    logic [NUM_TMR-1:0] hit, t_ie, t_lvl, cfg_we, cmp_we, irq_raw, stat_w;
    logic [31:0]        cfg_rd [NUM_TMR];
    logic [31:0]        cmp_rd [NUM_TMR];

    assign ctr_en = st_q.en;
    assign leg_w  = st_q.leg;
    assign stat_w = st_q.stat;
    assign ctr_ld = bus_wr && (bus_addr == ADDR_W'(OFF_CNT)) && !st_q.en;

    evt_main_ctr ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.en),
        .ld     (ctr_ld),
        .ld_val (bus_wdata),
        .cnt_q  (cnt_q)
    );

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_tmr
        assign cfg_we[n] = bus_wr && (bus_addr == ADDR_W'(tmr_cfg_addr(n)));
        assign cmp_we[n] = bus_wr && (bus_addr == ADDR_W'(tmr_cmp_addr(n)));

        evt_cmp_unit #(.PER_CAP(1'b1)) unit_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt    (cnt_q),
            .cnt_en (st_q.en),
            .cfg_we (cfg_we[n]),
            .cmp_we (cmp_we[n]),
            .wdata  (bus_wdata),
            .cfg_rd (cfg_rd[n]),
            .cmp_rd (cmp_rd[n]),
            .match  (hit[n]),
            .ie     (t_ie[n]),
            .lvl    (t_lvl[n])
        );

        assign irq_raw[n] = t_lvl[n] ? (st_q.stat[n] & t_ie[n]) : st_q.pulse[n];

        if (n < 2) begin : g_legacy_pair
            assign tmr_irq[n] = irq_raw[n] & ~st_q.leg;
        end else begin : g_plain
            assign tmr_irq[n] = irq_raw[n];
        end
    end

    assign legacy_irq0 = st_q.leg & irq_raw[0];
    assign legacy_irq8 = st_q.leg & irq_raw[1];

    always_comb begin
        st_d = st_q;
        if (bus_wr && bus_addr == ADDR_W'(OFF_GCFG)) begin
            st_d.en  = bus_wdata[0];
            st_d.leg = bus_wdata[1];
        end
        if (bus_wr && bus_addr == ADDR_W'(OFF_STAT)) begin
            st_d.stat = st_q.stat & ~bus_wdata[NUM_TMR-1:0];
        end
        st_d.stat  = st_d.stat | hit;
        st_d.pulse = hit & t_ie & ~t_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFF_CAPS): bus_rdata = CAPS_WORD;
            ADDR_W'(OFF_TICK): bus_rdata = TICK_FS;
            ADDR_W'(OFF_GCFG): bus_rdata = {30'd0, st_q.leg, st_q.en};
            ADDR_W'(OFF_STAT): bus_rdata = 32'(st_q.stat);
            ADDR_W'(OFF_CNT):  bus_rdata = cnt_q;
            default: begin
                for (int n = 0; n < NUM_TMR; n++) begin
                    if (bus_addr == ADDR_W'(tmr_cfg_addr(n))) bus_rdata = cfg_rd[n];
                    if (bus_addr == ADDR_W'(tmr_cmp_addr(n))) bus_rdata = cmp_rd[n];
                end
            end
        endcase
    end

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
    parameter int NUM_TMR = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en_q,
    input logic               ld,
    input logic [31:0]        cnt_q,
    input logic [NUM_TMR-1:0] match,
    input logic [NUM_TMR-1:0] stat_q,
    input logic               leg_q,
    input logic [NUM_TMR-1:0] tmr_irq,
    input logic               legacy_irq0,
    input logic               legacy_irq8
);

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> (cnt_q == $past(cnt_q) + 32'd1));

    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !ld) |=> $stable(cnt_q));

    p_match_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|match) |=> ((stat_q & $past(match)) == $past(match)));

    p_leg_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        leg_q |-> (tmr_irq[1:0] == 2'b00));

    p_leg_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !leg_q |-> (!legacy_irq0 && !legacy_irq8));

    p_line_needs_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_irq0 |-> stat_q[0]);

endmodule

bind evt_timer evt_timer_chk #(.NUM_TMR(NUM_TMR)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_q        (ctr_en),
    .ld          (ctr_ld),
    .cnt_q       (cnt_q),
    .match       (hit),
    .stat_q      (stat_w),
    .leg_q       (leg_w),
    .tmr_irq     (tmr_irq),
    .legacy_irq0 (legacy_irq0),
    .legacy_irq8 (legacy_irq8)
);

// File: tb/evt_timer_tb_top.sv
`timescale 1ns/1ps
module evt_timer_tb_top;

    localparam int          NT     = 3;
    localparam int          AW     = 12;
    localparam logic [15:0] VID    = 16'h5A17;
    localparam logic [7:0]  RID    = 8'h01;
    localparam logic [31:0] TICK   = 32'd10_000_000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NT-1:0] tmr_irq;
    logic          legacy_irq0, legacy_irq8;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    evt_timer #(.NUM_TMR(NT), .ADDR_W(AW), .VENDOR_ID(VID), .REV_ID(RID),
                .TICK_FS(TICK)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq),
        .legacy_irq0(legacy_irq0), .legacy_irq8(legacy_irq8)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = AW'(a);
        #0.5;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd('h000, v); chk("R1 caps", v, {VID, 1'b1, 1'b0, 1'b0, 5'(NT-1), RID});
        rd('h004, v); chk("R1 tick", v, TICK);
        rd('h010, v); chk("R1 gcfg", v, 32'd0);
        rd('h020, v); chk("R1 status", v, 32'd0);
        rd('h0F0, v); chk("R1 counter", v, 32'd0);
        rd('h100, v); chk("R1 tcfg0", v, 32'h10);
        rd('h140, v); chk("R1 tcfg2", v, 32'h10);
        chk("R1 lines", {29'd0, tmr_irq, legacy_irq0, legacy_irq8}, 32'd0);
    endtask

    task automatic t_counter;
        logic [31:0] a, b;
        wr('h0F0, 32'd100);
        rd('h0F0, a); chk("R3 load while disabled", a, 32'd100);
        idle(5);
        rd('h0F0, a); chk("R2 frozen while disabled", a, 32'd100);
        wr('h010, 32'd1);
        rd('h0F0, a);
        idle(7);
        rd('h0F0, b); chk("R2 step per clock", b - a, 32'd7);
        wr('h0F0, 32'd0);
        rd('h0F0, b); chk("R3 write ignored while enabled", 32'(b >= 32'd100), 32'd1);
        wr('h010, 32'd0);
        rd('h0F0, a);
        idle(4);
        rd('h0F0, b); chk("R2 hold after disable", b, a);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        wr('h0F0, 32'd0);
        wr('h020, 32'h7);
        wr('h100, 32'h6);
        wr('h108, 32'd20);
        wr('h010, 32'd1);
        idle(15);
        rd('h020, v); chk("R4 no status before match", v, 32'd0);
        chk("R8 line low before match", 32'(tmr_irq[0]), 32'd0);
        idle(10);
        rd('h020, v); chk("R4 status after match", v, 32'd1);
        chk("R8 level line high", 32'(tmr_irq[0]), 32'd1);
        idle(3);
        chk("R8 level line held", 32'(tmr_irq[0]), 32'd1);
        wr('h020, 32'd1);
        rd('h020, v); chk("R7 clear by writing one", v, 32'd0);
        chk("R8 line drops with status", 32'(tmr_irq[0]), 32'd0);
        wr('h010, 32'd0);
        wr('h0F0, 32'd0);
        wr('h010, 32'd1);
        idle(30);
        rd('h020, v); chk("R4 one-shot does not refire", v, 32'd0);
        wr('h010, 32'd0);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        int highs;
        wr('h0F0, 32'd0);
        wr('h020, 32'h7);
        wr('h120, 32'h4C);
        rd('h120, v); chk("R6 value-set reads one when armed", 32'(v[6]), 32'd1);
        wr('h128, 32'd10);
        rd('h120, v); chk("R6 value-set held after first write", 32'(v[6]), 32'd1);
        wr('h128, 32'd8);
        rd('h120, v); chk("R6 value-set clears after period write", 32'(v[6]), 32'd0);
        rd('h128, v); chk("R6 period write keeps compare", v, 32'd10);
        wr('h010, 32'd1);
        highs = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (tmr_irq[1]) highs++;
        end
        chk("R9 one-clock pulse per match", 32'(highs), 32'd4);
        wr('h010, 32'd0);
        rd('h128, v); chk("R5 comparator advanced by period", v, 32'd42);
        rd('h020, v); chk("R5 status from periodic match", v, 32'd2);
    endtask

    task automatic t_legacy;
        logic [31:0] v;
        wr('h0F0, 32'd0);
        wr('h020, 32'h7);
        wr('h100, 32'h6);
        wr('h120, 32'h6);
        wr('h140, 32'h6);
        wr('h108, 32'd5);
        wr('h128, 32'd5);
        wr('h148, 32'd5);
        wr('h010, 32'd3);
        idle(12);
        chk("R10 legacy line 0", 32'(legacy_irq0), 32'd1);
        chk("R10 legacy line 8", 32'(legacy_irq8), 32'd1);
        chk("R10 per-timer lines masked", 32'(tmr_irq), 32'h4);
        wr('h020, 32'd1);
        rd('h020, v); chk("R7 selective clear", v, 32'h6);
        chk("R10 legacy 0 follows timer 0", 32'(legacy_irq0), 32'd0);
        chk("R10 legacy 8 unaffected", 32'(legacy_irq8), 32'd1);
        wr('h020, 32'd0);
        rd('h020, v); chk("R7 zero write no effect", v, 32'h6);
        wr('h010, 32'd0);
        chk("R10 legacy lines idle when off", {30'd0, legacy_irq0, legacy_irq8}, 32'd0);
        chk("R10 per-timer lines restored", 32'(tmr_irq), 32'h6);
        wr('h140, 32'h2);
        rd('h020, v); chk("R11 status kept without enable", v, 32'h6);
        chk("R11 line low without enable", 32'(tmr_irq[2]), 32'd0);
    endtask

    task automatic t_no_ie;
        logic [31:0] v;
        wr('h020, 32'h7);
        wr('h0F0, 32'd0);
        wr('h100, 32'h2);
        wr('h108, 32'd4);
        wr('h010, 32'd1);
        idle(10);
        rd('h020, v); chk("R11 match sets status with enable off", 32'(v[0]), 32'd1);
        chk("R11 timer 0 line low", 32'(tmr_irq[0]), 32'd0);
        wr('h010, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_counter();
        t_oneshot();
        t_periodic();
        t_legacy();
        t_no_ie();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule